// File: doc/BRIEF.md
# Packet Deframer with CRC-16 Check

This block takes a byte-wide receive stream and splits it into packets. Each packet opens with a two-byte header: a 4-bit type code in the top nibble of the first byte, then a 12-bit payload byte count. The payload bytes follow, and two CRC bytes close the packet. The input has a valid strobe and a start marker, and the start marker is raised on the first header byte. The block reports the header fields with a one-cycle strobe. It forwards each payload byte on an output stream and marks the last one. After the closing CRC byte it gives a one-cycle completion strobe together with a pass or fail verdict.

The parser uses the length field to find where the payload ends and the CRC begins. The CRC is CRC-16 with polynomial 0x1021. It starts from all ones, is shifted most significant bit first, has no final inversion, and covers both header bytes and every payload byte. A start marker that arrives inside a packet drops that packet, raises a framing-error strobe and starts a fresh parse at the new byte. Every output is registered once, so every result appears one clock after the input byte that caused it.

Top module: `pkt_deframer`

## Requirements
- R1: When the second header byte is accepted, `hdr_valid` pulses for one cycle on the next clock. In that cycle `hdr_type` equals bits 7:4 of the first header byte, and `hdr_len` equals {first byte bits 3:0, second byte}. The DATA type code is 4'b0010.
- R2: Each payload byte comes out on `pl_data` with `pl_valid` high, exactly one cycle after it is accepted. Bytes keep their order, and exactly `hdr_len` beats are produced, up to 4095 of them.
- R3: `pl_last` is high together with the final payload beat of a packet and low at every other time.
- R4: The two bytes after the payload are the received CRC, high byte first. One cycle after the second CRC byte is accepted, `done` pulses. In that cycle `crc_ok` is high if the received CRC matches the computed CRC-16, and `crc_err` is high otherwise. The computed CRC uses polynomial 0x1021, initial value 16'hFFFF, MSB-first shifting and no final XOR, taken over both header bytes and all payload bytes. Outside a `done` cycle, both `crc_ok` and `crc_err` are low.
- R5: A packet with length 0 produces no payload beat, and the two bytes after its header are taken as its CRC.
- R6: A byte with `in_sop` high while a packet is in progress causes a one-cycle `frame_err` pulse on the next clock. The old packet produces no `done`, and the byte is taken as the first header byte of a new packet. A start marker when no packet is in progress raises no `frame_err`.
- R7: Cycles with `in_valid` low have no effect at any point, whatever `in_sop` is. Bytes with `in_sop` low that arrive outside a packet are ignored and produce no output.
- R8: During and after reset, before any input, every strobe output (`hdr_valid`, `pl_valid`, `pl_last`, `done`, `crc_ok`, `crc_err`, `frame_err`) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sop | input | 1 | Input byte is the first byte of a packet |
| in_data | input | 8 | Input byte |
| hdr_valid | output | 1 | One-cycle strobe: header fields valid |
| hdr_type | output | 4 | Packet type code |
| hdr_len | output | 12 | Payload length in bytes |
| pl_valid | output | 1 | Payload byte present |
| pl_data | output | 8 | Payload byte |
| pl_last | output | 1 | Final payload byte of the packet |
| done | output | 1 | One-cycle strobe: packet complete |
| crc_ok | output | 1 | CRC matched (with done) |
| crc_err | output | 1 | CRC mismatched (with done) |
| frame_err | output | 1 | One-cycle strobe: packet cut short by a new start marker |

## Verification
The bench targets a set of corner cases:
- A zero-length packet. A parser that entered the payload state here would swallow the CRC bytes as payload and never report completion.
- The maximum length of 4095. An off-by-one in the byte counter would move `pl_last` or misread the first CRC byte.
- Start markers injected inside the header, the payload and the CRC field. A wrong design would report a stale verdict or run the CRC from a stale seed.
- Idle gaps with a random `in_sop` inside packets, and corrupted CRC bytes. A wrong design would count stalls as bytes or accept a bad packet.

// File: rtl/pkt_deframer_pkg.sv
package pkt_deframer_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_PAY,
      ST_CRCH,
      ST_CRCL
   } dfr_state_e;

   localparam logic [3:0] PT_CONTROL = 4'b0001;
   localparam logic [3:0] PT_DATA    = 4'b0010;
   localparam logic [3:0] PT_ACK     = 4'b0011;
   localparam logic [3:0] PT_ERROR   = 4'b0100;

endpackage

// File: rtl/pkt_crc16_unit.sv
module pkt_crc16_unit #(
   parameter int                BYTE_W = 8,
   parameter int                CRC_W  = 16,
   parameter logic [CRC_W-1:0]  POLY   = 16'h1021,
   parameter logic [CRC_W-1:0]  INIT   = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              advance,
   input  logic [BYTE_W-1:0] din,
   output logic [CRC_W-1:0]  crc_q
);

   if (BYTE_W > CRC_W) begin : g_bad_width
      $error("pkt_crc16_unit: BYTE_W must not exceed CRC_W");
   end

   // Bit-serial chain unrolled over one byte, MSB of the byte first.
   logic [CRC_W-1:0] chain [0:BYTE_W];

   assign chain[0] = restart ? INIT : crc_q;

   for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
      logic fb;
      assign fb           = chain[i][CRC_W-1] ^ din[BYTE_W-1-i];
      assign chain[i+1]   = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= INIT;
      end else if (restart || advance) begin
         crc_q <= chain[BYTE_W];
      end
   end

endmodule

// File: rtl/pkt_frame_parser.sv
module pkt_frame_parser
   import pkt_deframer_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int TYPE_W = 4,
   parameter int LEN_W  = 12,
   parameter int CRC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [BYTE_W-1:0] in_data,
   input  logic [CRC_W-1:0]  crc_i,
   output logic              crc_restart,
   output logic              crc_advance,
   output logic              ev_hdr,
   output logic [TYPE_W-1:0] ev_type,
   output logic [LEN_W-1:0]  ev_len,
   output logic              ev_pay,
   output logic              ev_last,
   output logic              ev_done,
   output logic              ev_match,
   output logic              ev_ferr
);

   localparam int              HDR_W   = TYPE_W + LEN_W;
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

   dfr_state_e        state_q, state_d;
   logic [BYTE_W-1:0] byte0_q;
   logic [BYTE_W-1:0] crc_hi_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [HDR_W-1:0]  hdr_word;
   logic              start;
   logic              beat;

   assign beat     = in_valid && !in_sop;
   assign start    = in_valid && in_sop;
   assign hdr_word = {byte0_q, in_data};
   assign ev_type  = hdr_word[HDR_W-1 -: TYPE_W];
   assign ev_len   = hdr_word[LEN_W-1:0];

   assign ev_ferr  = start && (state_q != ST_IDLE);
   assign ev_hdr   = beat && (state_q == ST_HDR);
   assign ev_pay   = beat && (state_q == ST_PAY);
   assign ev_last  = ev_pay && (cnt_q == (len_q - LEN_ONE));
   assign ev_done  = beat && (state_q == ST_CRCL);
   assign ev_match = ({crc_hi_q, in_data} == crc_i);

   assign crc_restart = start;
   assign crc_advance = ev_hdr || ev_pay;

   always_comb begin
      state_d = state_q;
      if (start) begin
         state_d = ST_HDR;
      end else if (beat) begin
         case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_HDR:  state_d = (ev_len == '0) ? ST_CRCH : ST_PAY;
            ST_PAY:  state_d = ev_last ? ST_CRCH : ST_PAY;
            ST_CRCH: state_d = ST_CRCL;
            ST_CRCL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         byte0_q  <= '0;
         crc_hi_q <= '0;
         len_q    <= '0;
         cnt_q    <= '0;
      end else begin
         state_q <= state_d;
         if (start) begin
            byte0_q <= in_data;
         end
         if (ev_hdr) begin
            len_q <= ev_len;
            cnt_q <= '0;
         end else if (ev_pay) begin
            cnt_q <= cnt_q + LEN_ONE;
         end
         if (beat && (state_q == ST_CRCH)) begin
            crc_hi_q <= in_data;
         end
      end
   end

   // R2
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PAY) |-> (cnt_q < len_q));

   // R5
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_hdr && (ev_len == '0)) |=> (state_q == ST_CRCH));

endmodule

// File: rtl/pkt_out_stage.sv
module pkt_out_stage #(
   parameter int BYTE_W = 8,
   parameter int TYPE_W = 4,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_hdr,
   input  logic [TYPE_W-1:0] ev_type,
   input  logic [LEN_W-1:0]  ev_len,
   input  logic              ev_pay,
   input  logic              ev_last,
   input  logic [BYTE_W-1:0] ev_data,
   input  logic              ev_done,
   input  logic              ev_match,
   input  logic              ev_ferr,
   output logic              hdr_valid,
   output logic [TYPE_W-1:0] hdr_type,
   output logic [LEN_W-1:0]  hdr_len,
   output logic              pl_valid,
   output logic [BYTE_W-1:0] pl_data,
   output logic              pl_last,
   output logic              done,
   output logic              crc_ok,
   output logic              crc_err,
   output logic              frame_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_valid <= 1'b0;
         hdr_type  <= '0;
         hdr_len   <= '0;
         pl_valid  <= 1'b0;
         pl_data   <= '0;
         pl_last   <= 1'b0;
         done      <= 1'b0;
         crc_ok    <= 1'b0;
         crc_err   <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         hdr_valid <= ev_hdr;
         pl_valid  <= ev_pay;
         pl_last   <= ev_last;
         done      <= ev_done;
         crc_ok    <= ev_done && ev_match;
         crc_err   <= ev_done && !ev_match;
         frame_err <= ev_ferr;
         if (ev_hdr) begin
            hdr_type <= ev_type;
            hdr_len  <= ev_len;
         end
         if (ev_pay) begin
            pl_data <= ev_data;
         end
      end
   end

   // R4
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (crc_ok != crc_err));

   // R4
   verdict_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!crc_ok && !crc_err));

   // R3
   last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pl_last |-> pl_valid);

   // R1
   hdr_pay_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_valid && pl_valid));

endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer #(
   parameter int               BYTE_W   = 8,
   parameter int               TYPE_W   = 4,
   parameter int               LEN_W    = 12,
   parameter int               CRC_W    = 16,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [BYTE_W-1:0] in_data,
   output logic              hdr_valid,
   output logic [TYPE_W-1:0] hdr_type,
   output logic [LEN_W-1:0]  hdr_len,
   output logic              pl_valid,
   output logic [BYTE_W-1:0] pl_data,
   output logic              pl_last,
   output logic              done,
   output logic              crc_ok,
   output logic              crc_err,
   output logic              frame_err
);

   localparam int HDR_W = TYPE_W + LEN_W;

   if (HDR_W != 2 * BYTE_W) begin : g_bad_hdr
      $error("pkt_deframer: TYPE_W + LEN_W must span two bytes");
   end
   if (CRC_W != 2 * BYTE_W) begin : g_bad_crc
      $error("pkt_deframer: CRC_W must span two bytes");
   end

   logic [CRC_W-1:0]  crc_val;
   logic              crc_restart, crc_advance;
   logic              ev_hdr, ev_pay, ev_last, ev_done, ev_match, ev_ferr;
   logic [TYPE_W-1:0] ev_type;
   logic [LEN_W-1:0]  ev_len;

   pkt_crc16_unit #(
      .BYTE_W (BYTE_W),
      .CRC_W  (CRC_W),
      .POLY   (CRC_POLY),
      .INIT   (CRC_INIT)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (crc_restart),
      .advance (crc_advance),
      .din     (in_data),
      .crc_q   (crc_val)
   );

   pkt_frame_parser #(
      .BYTE_W (BYTE_W),
      .TYPE_W (TYPE_W),
      .LEN_W  (LEN_W),
      .CRC_W  (CRC_W)
   ) u_parse (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_sop      (in_sop),
      .in_data     (in_data),
      .crc_i       (crc_val),
      .crc_restart (crc_restart),
      .crc_advance (crc_advance),
      .ev_hdr      (ev_hdr),
      .ev_type     (ev_type),
      .ev_len      (ev_len),
      .ev_pay      (ev_pay),
      .ev_last     (ev_last),
      .ev_done     (ev_done),
      .ev_match    (ev_match),
      .ev_ferr     (ev_ferr)
   );

   pkt_out_stage #(
      .BYTE_W (BYTE_W),
      .TYPE_W (TYPE_W),
      .LEN_W  (LEN_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_hdr    (ev_hdr),
      .ev_type   (ev_type),
      .ev_len    (ev_len),
      .ev_pay    (ev_pay),
      .ev_last   (ev_last),
      .ev_data   (in_data),
      .ev_done   (ev_done),
      .ev_match  (ev_match),
      .ev_ferr   (ev_ferr),
      .hdr_valid (hdr_valid),
      .hdr_type  (hdr_type),
      .hdr_len   (hdr_len),
      .pl_valid  (pl_valid),
      .pl_data   (pl_data),
      .pl_last   (pl_last),
      .done      (done),
      .crc_ok    (crc_ok),
      .crc_err   (crc_err),
      .frame_err (frame_err)
   );

   // R6
   ferr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> $past(in_valid && in_sop));

   // R4
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(in_valid && !in_sop));

endmodule

// File: tb/sim_pkt_deframer.sv
`timescale 1ns/1ps
module sim_pkt_deframer;

   localparam int CLK_HALF = 4;  // 125 MHz

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sop = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        hdr_valid, pl_valid, pl_last, done, crc_ok, crc_err, frame_err;
   logic [3:0]  hdr_type;
   logic [11:0] hdr_len;
   logic [7:0]  pl_data;

   always #CLK_HALF clk = ~clk;

   pkt_deframer u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
      .hdr_valid(hdr_valid), .hdr_type(hdr_type), .hdr_len(hdr_len),
      .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
      .done(done), .crc_ok(crc_ok), .crc_err(crc_err), .frame_err(frame_err)
   );

   int nchk = 0;
   int nfail = 0;
   int obs_beats = 0;
   int obs_ok = 0;
   int obs_err = 0;
   int obs_ferr = 0;

   // expected outputs for the next sampling point
   logic        e_hv = 0, e_pv = 0, e_last = 0, e_done = 0, e_ok = 0, e_ferr = 0;
   logic [3:0]  e_type = 0;
   logic [11:0] e_len = 0;
   logic [7:0]  e_data = 0;

   // specification model state: 0 idle, 1 header, 2 payload, 3 crc high, 4 crc low
   int          m_st = 0;
   int          m_cnt = 0;
   logic [7:0]  m_b0 = 0;
   logic [7:0]  m_hi = 0;
   logic [11:0] m_len = 0;
   logic [15:0] m_crc = 0;

   logic [7:0]  pkt [0:4101];

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int k = 7; k >= 0; k--) begin
         logic f;
         f = r[15] ^ b[k];
         r = {r[14:0], 1'b0};
         if (f) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   task automatic chk(input logic good, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!good) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_outputs();
      logic [31:0] a, e;
      a = hdr_valid ? {15'd0, 1'b1, hdr_type, hdr_len} : 32'd0;
      e = e_hv ? {15'd0, 1'b1, e_type, e_len} : 32'd0;
      chk(a === e, "R1 header", a, e);
      a = pl_valid ? {23'd0, 1'b1, pl_data} : 32'd0;
      e = e_pv ? {23'd0, 1'b1, e_data} : 32'd0;
      chk(a === e, "R2 payload", a, e);
      chk(pl_last === e_last, "R3 last", 32'(pl_last), 32'(e_last));
      a = {29'd0, done, crc_ok, crc_err};
      e = {29'd0, e_done, e_done && e_ok, e_done && !e_ok};
      chk(a === e, "R4 verdict", a, e);
      chk(frame_err === e_ferr, "R6 frame_err", 32'(frame_err), 32'(e_ferr));
      if (pl_valid === 1'b1) obs_beats++;
      if (done === 1'b1 && crc_ok === 1'b1) obs_ok++;
      if (done === 1'b1 && crc_err === 1'b1) obs_err++;
      if (frame_err === 1'b1) obs_ferr++;
   endtask

   task automatic step(input logic v, input logic s, input logic [7:0] d);
      @(negedge clk);
      check_outputs();
      e_hv = 0; e_pv = 0; e_last = 0; e_done = 0; e_ok = 0; e_ferr = 0;
      if (v) begin
         if (s) begin
            if (m_st != 0) e_ferr = 1;
            m_st  = 1;
            m_b0  = d;
            m_crc = crc_upd(16'hFFFF, d);
         end else begin
            case (m_st)
               1: begin
                  e_hv   = 1;
                  e_type = m_b0[7:4];
                  e_len  = {m_b0[3:0], d};
                  m_len  = {m_b0[3:0], d};
                  m_crc  = crc_upd(m_crc, d);
                  m_cnt  = 0;
                  m_st   = (m_len == 0) ? 3 : 2;
               end
               2: begin
                  e_pv   = 1;
                  e_data = d;
                  e_last = (m_cnt == int'(m_len) - 1);
                  m_crc  = crc_upd(m_crc, d);
                  m_cnt++;
                  if (e_last) m_st = 3;
               end
               3: begin
                  m_hi = d;
                  m_st = 4;
               end
               4: begin
                  e_done = 1;
                  e_ok   = ({m_hi, d} == m_crc);
                  m_st   = 0;
               end
               default: ;
            endcase
         end
      end
      in_valid = v;
      in_sop   = s;
      in_data  = d;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'($urandom % 2), 8'($urandom));
   endtask

   // cut = 0 sends the whole packet, otherwise only the first cut bytes
   task automatic send_pkt(input logic [3:0] typ, input int len, input bit bad,
                           input bit gaps, input int cut);
      logic [15:0] c;
      int n;
      pkt[0] = {typ, 4'(len >> 8)};
      pkt[1] = 8'(len);
      for (int i = 0; i < len; i++) pkt[2 + i] = 8'($urandom);
      c = 16'hFFFF;
      for (int i = 0; i < len + 2; i++) c = crc_upd(c, pkt[i]);
      if (bad) c[0] = ~c[0];
      pkt[len + 2] = c[15:8];
      pkt[len + 3] = c[7:0];
      n = (cut == 0) ? len + 4 : cut;
      for (int i = 0; i < n; i++) begin
         if (gaps && ($urandom % 4 == 0)) idle(1 + int'($urandom % 3));
         step(1'b1, (i == 0), pkt[i]);
      end
   endtask

   initial begin
      #(2 * CLK_HALF * 200000);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      int b0, ok0, err0, f0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R8: outputs low during reset
      chk({hdr_valid, pl_valid, pl_last, done, crc_ok, crc_err, frame_err} === 7'd0,
          "R8 reset", 32'({hdr_valid, pl_valid, pl_last, done, crc_ok, crc_err, frame_err}), 32'd0);
      rst_n = 1'b1;
      idle(2);

      // R7: stray bytes outside a packet
      b0 = obs_beats;
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'($urandom));
      idle(2);
      chk(obs_beats == b0, "R7 stray", 32'(obs_beats), 32'(b0));

      // R1 R4: DATA packet, one byte
      ok0 = obs_ok;
      send_pkt(4'b0010, 1, 0, 0, 0);
      idle(2);
      chk(obs_ok == ok0 + 1, "R4 good pkt", 32'(obs_ok), 32'(ok0 + 1));

      // R5: zero-length packet
      b0 = obs_beats; ok0 = obs_ok;
      send_pkt(4'b0011, 0, 0, 0, 0);
      idle(2);
      chk(obs_beats == b0, "R5 no beats", 32'(obs_beats), 32'(b0));
      chk(obs_ok == ok0 + 1, "R5 verdict", 32'(obs_ok), 32'(ok0 + 1));

      // R4: corrupted CRC
      err0 = obs_err;
      send_pkt(4'b0001, 5, 1, 0, 0);
      idle(2);
      chk(obs_err == err0 + 1, "R4 bad pkt", 32'(obs_err), 32'(err0 + 1));

      // R6: restart in payload, in header and in CRC field
      f0 = obs_ferr; ok0 = obs_ok;
      send_pkt(4'b0010, 10, 0, 0, 5);
      send_pkt(4'b0100, 3, 0, 0, 0);
      send_pkt(4'b0010, 7, 0, 0, 1);
      send_pkt(4'b0010, 2, 0, 0, 5);
      send_pkt(4'b0001, 4, 0, 1, 0);
      idle(2);
      chk(obs_ferr == f0 + 3, "R6 count", 32'(obs_ferr), 32'(f0 + 3));
      chk(obs_ok == ok0 + 2, "R6 dropped", 32'(obs_ok), 32'(ok0 + 2));

      // R2 R3: maximum length
      b0 = obs_beats;
      send_pkt(4'b0010, 4095, 0, 0, 0);
      idle(2);
      chk(obs_beats == b0 + 4095, "R2 max len", 32'(obs_beats), 32'(b0 + 4095));

      // random traffic with gaps, bad CRCs and early restarts
      for (int p = 0; p < 300; p++) begin
         int len, cut;
         len = int'($urandom % 41);
         cut = ($urandom % 10 == 0) ? 1 + int'($urandom % (len + 3)) : 0;
         send_pkt(4'($urandom), len, ($urandom % 5 == 0), 1'b1, cut);
         if ($urandom % 3 == 0) idle(1 + int'($urandom % 3));
         if ($urandom % 8 == 0) step(1'b1, 1'b0, 8'($urandom));
      end
      idle(3);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule